// File: doc/BRIEF.md
# Memory-Card Status and Insert-Event Register Block

This block is a small register slice on the peripheral side of a chip. It tells software whether a memory card is present and whether that card is write-protected. It also raises one interrupt line when a card has been inserted. Software reaches it through a simple word-indexed register port. A read is requested with `rd_en` and its data comes back on the next cycle. A write takes effect on the clock edge where `wr_en` is high.

The status word mixes two kinds of bit. The write-protect bit is a live copy of its input level, registered once. The card-insert bit is sticky: the first cycle the insert input is high sets it, and it stays set until software writes a one to its position. The interrupt output is driven only by the sticky bit. Two further registers return constant identification and decode words. A flash-programming register reads zero, and writes to it are dropped, as are writes to the two constant registers.

The reset input is asserted asynchronously and is released through a local synchronizer, so the block leaves reset on a clock edge.

Top module: `cardstat_regs`

## Requirements
- R1: While reset is applied and after it is released, `card_irq` and `rd_valid` are 0, and the status word (index 2) reads 0 when both card inputs are low.
- R2: A read of index 0 returns 0x41034003, a read of index 3 returns 0x00000011, and a read of index 1 returns 0.
- R3: Bit 0 of index 2 reads the `wp_level` value present one cycle before the read request, and follows the input both when it rises and when it falls.
- R4: Bit 3 of index 2 becomes 1 on the clock edge after `ins_level` is seen high, and `ins_level` returning low does not clear it.
- R5: `card_irq` is high exactly when bit 3 of index 2 is set, and it stays high until a clearing write.
- R6: A write to index 2 with data bit 3 equal to 1 clears bit 3 and drops `card_irq` on that edge. A write to index 2 with data bit 3 equal to 0 changes nothing.
- R7: If `ins_level` is high on the edge of a clearing write, bit 3 stays set (setting wins over clearing).
- R8: Writes to indices 0, 1 and 3, and to any index above 3, change no register value and do not touch `card_irq`.
- R9: Reads of any index above 3 return 0, and bits of index 2 other than 0 and 3 read 0.
- R10: Each cycle with `rd_en` high produces exactly one cycle of `rd_valid` on the next cycle, carrying that read's data on `rd_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_idx | input | IDX_W (4) | Word index of the register being accessed |
| rd_en | input | 1 | Read request, one per cycle |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data, valid with `rd_valid` |
| rd_valid | output | 1 | Read data valid, one cycle after `rd_en` |
| wp_level | input | 1 | Card write-protect level |
| ins_level | input | 1 | Card insert level |
| card_irq | output | 1 | Card-insert interrupt, held until cleared |

## Verification
The assertions check, on every cycle, the relations that hold between ports: the interrupt rising after the insert input is seen, staying high unless a clearing write arrives, falling only after one, and surviving a clear that meets a high insert input. They also check the read latency and the values returned for the constant, unlisted and status indices. Only the bench's scenarios show the full sequences. These are: an insert pulse that has already gone away when software reads, a write with the wrong bit that must not clear, write-protect toggling between reads, and writes to every read-only or unlisted index while the event is pending.

// File: rtl/cardstat_pkg.sv
package cardstat_pkg;

  localparam int DATA_W = 32;

  typedef logic [DATA_W-1:0] word_t;

  // word indices software decodes
  localparam int IDX_IDENT  = 0;
  localparam int IDX_FLASH  = 1;
  localparam int IDX_STATUS = 2;
  localparam int IDX_DECODE = 3;

  // bit positions inside the status word
  localparam int BIT_WPROT  = 0;
  localparam int BIT_INSERT = 3;

  typedef struct packed {
    logic ident;
    logic flash;
    logic status;
    logic decode;
  } hit_t;

endpackage

// File: rtl/cardstat_rstsync.sv
module cardstat_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain_q;
  logic [LAST:0] chain_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb chain_d = 1'b1;
    end else begin : g_multi
      always_comb chain_d = {chain_q[LAST-1:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign srst_n = chain_q[LAST];
endmodule

// File: rtl/cardstat_decode.sv
module cardstat_decode
  import cardstat_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic [IDX_W-1:0] idx,
  output hit_t             hit
);
  localparam int NUM_IDX = 4;

  logic [NUM_IDX-1:0] onehot;

  generate
    for (genvar g = 0; g < NUM_IDX; g++) begin : g_cmp
      assign onehot[g] = (idx == IDX_W'(g));
    end
  endgenerate

  always_comb begin
    hit.ident  = onehot[IDX_IDENT];
    hit.flash  = onehot[IDX_FLASH];
    hit.status = onehot[IDX_STATUS];
    hit.decode = onehot[IDX_DECODE];
  end
endmodule

// File: rtl/cardstat_latch.sv
module cardstat_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic wp_level,
  input  logic ins_level,
  input  logic clr_req,
  output logic wp_q,
  output logic ins_q
);
  logic wp_d;
  logic ins_en;
  logic ins_d;

  // next state: write-protect tracks every cycle; insert latch loads on a
  // set or a clear, and a high input wins over a clear in the same cycle
  always_comb begin
    wp_d   = wp_level;
    ins_en = ins_level | clr_req;
    ins_d  = ins_level;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= 1'b0;
      ins_q <= 1'b0;
    end else begin
      wp_q <= wp_d;
      if (ins_en) ins_q <= ins_d;
    end
  end
endmodule

// File: rtl/cardstat_rdmux.sv
module cardstat_rdmux
  import cardstat_pkg::*;
#(
  parameter word_t ID_WORD  = 32'h4103_4003,
  parameter word_t DEC_WORD = 32'h0000_0011
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  rd_en,
  input  hit_t  hit,
  input  logic  wp_q,
  input  logic  ins_q,
  output word_t rd_data,
  output logic  rd_valid
);
  word_t status_w;
  word_t data_d;

  always_comb begin
    status_w             = '0;
    status_w[BIT_WPROT]  = wp_q;
    status_w[BIT_INSERT] = ins_q;
    data_d = '0;
    unique case (1'b1)
      hit.ident:  data_d = ID_WORD;
      hit.status: data_d = status_w;
      hit.decode: data_d = DEC_WORD;
      default:    data_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= data_d;
    end
  end
endmodule

// File: rtl/cardstat_regs.sv
module cardstat_regs
  import cardstat_pkg::*;
#(
  parameter int    IDX_W      = 4,
  parameter int    RST_STAGES = 2,
  parameter word_t ID_WORD    = 32'h4103_4003,
  parameter word_t DEC_WORD   = 32'h0000_0011
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  reg_idx,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  input  logic              wp_level,
  input  logic              ins_level,
  output logic              card_irq
);
  logic rst_q_n;
  hit_t hit;
  logic clr_req;
  logic wp_q;
  logic ins_q;

  cardstat_rstsync #(.STAGES(RST_STAGES)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_q_n)
  );

  cardstat_decode #(.IDX_W(IDX_W)) u_dec (
    .idx (reg_idx),
    .hit (hit)
  );

  // only a one in the insert position of a status write clears the event
  always_comb clr_req = wr_en & hit.status & wr_data[BIT_INSERT];

  cardstat_latch u_lat (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .wp_level  (wp_level),
    .ins_level (ins_level),
    .clr_req   (clr_req),
    .wp_q      (wp_q),
    .ins_q     (ins_q)
  );

  cardstat_rdmux #(.ID_WORD(ID_WORD), .DEC_WORD(DEC_WORD)) u_rd (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .rd_en    (rd_en),
    .hit      (hit),
    .wp_q     (wp_q),
    .ins_q    (ins_q),
    .rd_data  (rd_data),
    .rd_valid (rd_valid)
  );

  assign card_irq = ins_q;
endmodule

// File: rtl/cardstat_chk.sv
module cardstat_chk #(
  parameter int          IDX_W    = 4,
  parameter logic [31:0] ID_WORD  = 32'h4103_4003,
  parameter logic [31:0] DEC_WORD = 32'h0000_0011
) (
  input logic             clk,
  input logic             rst_n,
  input logic [IDX_W-1:0] reg_idx,
  input logic             rd_en,
  input logic             wr_en,
  input logic [31:0]      wr_data,
  input logic [31:0]      rd_data,
  input logic             rd_valid,
  input logic             wp_level,
  input logic             ins_level,
  input logic             card_irq
);
  logic [1:0] cyc;
  logic       clr_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cyc <= 2'd0;
    else if (cyc != 2'd3) cyc <= cyc + 2'd1;
  end

  assign clr_w = wr_en && (reg_idx == IDX_W'(2)) && wr_data[3];

  // R4
  ins_sets_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ins_level |=> card_irq);

  // R5
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (card_irq && !clr_w) |=> card_irq);

  // R6
  irq_fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(card_irq) |-> $past(clr_w));

  // R7
  set_beats_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_w && ins_level) |=> card_irq);

  // R10
  valid_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);

  // R10
  valid_has_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(rd_en));

  // R2
  ident_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && $past(reg_idx) == IDX_W'(0)) |-> rd_data == ID_WORD);

  // R2
  decode_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && $past(reg_idx) == IDX_W'(3)) |-> rd_data == DEC_WORD);

  // R9
  unlisted_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && ($past(reg_idx) > IDX_W'(3) || $past(reg_idx) == IDX_W'(1)))
      |-> rd_data == 32'd0);

  // R3
  wprot_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && cyc == 2'd3 && $past(reg_idx) == IDX_W'(2))
      |-> rd_data[0] == $past(wp_level, 2));

  // R5
  insert_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && $past(reg_idx) == IDX_W'(2)) |-> rd_data[3] == $past(card_irq));
endmodule

bind cardstat_regs cardstat_chk #(
  .IDX_W    (IDX_W),
  .ID_WORD  (ID_WORD),
  .DEC_WORD (DEC_WORD)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_q_n),
  .reg_idx   (reg_idx),
  .rd_en     (rd_en),
  .wr_en     (wr_en),
  .wr_data   (wr_data),
  .rd_data   (rd_data),
  .rd_valid  (rd_valid),
  .wp_level  (wp_level),
  .ins_level (ins_level),
  .card_irq  (card_irq)
);

// File: tb/sim_cardstat_regs.sv
`timescale 1ns/1ps
module sim_cardstat_regs;
  localparam int IDX_W = 4;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [IDX_W-1:0] reg_idx;
  logic             rd_en;
  logic             wr_en;
  logic [31:0]      wr_data;
  logic [31:0]      rd_data;
  logic             rd_valid;
  logic             wp_level;
  logic             ins_level;
  logic             card_irq;

  int compared   = 0;
  int mismatched = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  cardstat_regs u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_idx   (reg_idx),
    .rd_en     (rd_en),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .rd_data   (rd_data),
    .rd_valid  (rd_valid),
    .wp_level  (wp_level),
    .ins_level (ins_level),
    .card_irq  (card_irq)
  );

  task automatic check(input logic [31:0] got, input logic [31:0] exp, input string tag);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // every task is entered and left two time units after a rising edge
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2;
    end
  endtask

  task automatic rd(input int idx, input logic [31:0] exp, input string tag);
    reg_idx = IDX_W'(idx);
    rd_en   = 1'b1;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(posedge clk); #2;
    rd_en = 1'b0;
  endtask

  task automatic wr(input int idx, input logic [31:0] data);
    reg_idx = IDX_W'(idx);
    wr_data = data;
    wr_en   = 1'b1;
    @(posedge clk); #2;
    wr_en = 1'b0;
  endtask

  // monitor: pops one expectation per valid read beat
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) begin
        compared++;
        mismatched++;
        $display("FAIL R10: got unrequested read beat %h expected none", rd_data);
      end else begin
        check(rd_data, exp_q.pop_front(), tag_q.pop_front());
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_idx = '0; rd_en = 1'b0; wr_en = 1'b0; wr_data = '0;
    wp_level = 1'b0; ins_level = 1'b0;
    idle(3);
    check({31'd0, card_irq}, 32'd0, "R1 irq in reset");
    check({31'd0, rd_valid}, 32'd0, "R1 rd_valid in reset");
    rst_n = 1'b1;
    idle(4);
    check({31'd0, card_irq}, 32'd0, "R1 irq after reset");
    rd(2, 32'h0, "R1 status after reset");

    rd(0, 32'h4103_4003, "R2 ident");
    rd(1, 32'h0, "R2 flash reads zero");
    rd(3, 32'h0000_0011, "R2 decode");
    rd(7, 32'h0, "R9 index 7");
    rd(15, 32'h0, "R9 index 15");
    rd(4, 32'h0, "R9 index 4");

    // write-protect follows both ways
    wp_level = 1'b1; idle(1);
    rd(2, 32'h1, "R3 wp rise");
    wp_level = 1'b0; idle(1);
    rd(2, 32'h0, "R3 wp fall");

    // short insert pulse latches
    ins_level = 1'b1; idle(1);
    ins_level = 1'b0; idle(2);
    check({31'd0, card_irq}, 32'd1, "R4 R5 irq after pulse");
    rd(2, 32'h8, "R4 latched after input low");
    wp_level = 1'b1; idle(1);
    rd(2, 32'h9, "R3 R9 both bits");
    wp_level = 1'b0;

    // write without bit 3 does not clear
    wr(2, 32'hFFFF_FFF7); idle(1);
    check({31'd0, card_irq}, 32'd1, "R6 no clear without bit3");
    rd(2, 32'h8, "R6 status kept");

    // writes elsewhere are dropped
    wr(0, 32'hFFFF_FFFF);
    wr(1, 32'hFFFF_FFFF);
    wr(3, 32'hFFFF_FFFF);
    wr(6, 32'hFFFF_FFFF);
    wr(15, 32'hFFFF_FFFF);
    check({31'd0, card_irq}, 32'd1, "R8 irq kept after other writes");
    rd(0, 32'h4103_4003, "R8 ident after write");
    rd(1, 32'h0, "R8 flash after write");
    rd(3, 32'h0000_0011, "R8 decode after write");
    rd(6, 32'h0, "R8 unlisted after write");
    rd(2, 32'h8, "R8 status after writes");

    // proper clear
    wr(2, 32'h0000_0008);
    check({31'd0, card_irq}, 32'd0, "R6 irq cleared");
    rd(2, 32'h0, "R6 status cleared");

    // clear while insert still high: set wins
    ins_level = 1'b1; idle(1);
    wr(2, 32'h0000_0008);
    check({31'd0, card_irq}, 32'd1, "R7 set wins over clear");
    rd(2, 32'h8, "R7 status still set");
    ins_level = 1'b0; idle(1);
    wr(2, 32'hFFFF_FFFF);
    check({31'd0, card_irq}, 32'd0, "R6 clear after input low");
    rd(2, 32'h0, "R6 status zero");

    // back-to-back reads
    rd(0, 32'h4103_4003, "R10 burst a");
    rd(3, 32'h0000_0011, "R10 burst b");
    rd(2, 32'h0, "R10 burst c");
    idle(3);

    compared++;
    if (exp_q.size() != 0) begin
      mismatched++;
      $display("FAIL R10: got %0d reads outstanding expected 0", exp_q.size());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule